// File: doc/BRIEF.md
# Fetch Packet Execute-Packet Splitter

This block sits in the front end of a VLIW core, between instruction fetch and decode. Fetch hands it one 256-bit fetch packet of eight 32-bit words at a time. The splitter breaks that packet into execute packets, which are groups of instructions meant to issue in the same cycle. It then presents one execute packet per handshake as eight 32-bit lanes with a valid mask.

A fetch packet comes in one of two forms, told apart by its top word.

- **Plain packet.** All eight words are 32-bit instructions. Bit 0 of each word chains it to the next word.
- **Compact packet.** The top word is a header. It marks which of the seven lower words carry two 16-bit instructions, and it supplies their chaining bits. One packet can therefore hold up to fourteen instructions.

A 16-bit instruction is zero-extended into its lane and flagged as compact. Execute packets never span two fetch packets.

Both data edges use valid/ready.

- **Input edge.** A fetch packet transfers on a clock edge where `fp_valid` and `fp_ready` are both high. `fp_ready` is high only while no instruction of the previous packet is still waiting. The input therefore stalls fetch for as many cycles as the packet needs.
- **Output edge.** An execute packet transfers on an edge where `ep_valid` and `ep_ready` are both high. While `ep_ready` is low, the offered packet and its flags hold still. There is no limit on how long downstream may hold `ep_ready` low.

Top module: `fetch_packet_splitter`

## Requirements
- R1: After a synchronous reset, `ep_valid` is 0, `ep_mask` is 0 and `fp_ready` is 1.
- R2: In a plain packet, bit 0 of each word is its chain bit. If it is 1, the next word joins the same execute packet. If it is 0, the next word starts a new one. Word 0 sits at bits [31:0] and is issued first; lanes fill from lane 0 upward in ascending address order.
- R3: Each execute packet holds 1 to 8 instructions in a contiguous run of lanes starting at lane 0. Lanes outside `ep_mask` read as zero.
- R4: A chain bit set on the last instruction of a fetch packet has no effect. The next fetch packet starts a new execute packet.
- R5: A packet is compact only when bits [255:252] equal 4'b1110. Any other value, including near values such as 4'b0110 or 4'b1111, gives a plain packet of eight instructions. A header word is never issued.
- R6: In a compact packet, header bit k (k = 0..6) set means word k holds two 16-bit instructions. The low half is issued before the high half. Each half is zero-extended into its lane, and its `ep_compact` bit is 1. Lanes holding 32-bit instructions have `ep_compact` at 0.
- R7: In a compact packet, the chain bit of half h (0 = low, 1 = high) of word k is header bit 14+2k+h. An unflagged 32-bit word in a compact packet uses its own bit 0 as its chain bit.
- R8: A chain running longer than eight instructions is cut after eight. The remainder forms the next execute packet.
- R9: Execute packets of one fetch packet are offered in address order, one per handshake. `ep_last` is 1 exactly on the final one.
- R10: While `ep_valid` is 1 and `ep_ready` is 0, all `ep_*` outputs keep their values.
- R11: `fp_ready` and `ep_valid` are never high together. `fp_ready` returns to 1 in the cycle after the handshake of the last execute packet, and a packet accepted on an edge shows `ep_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fp_valid | input | 1 | Fetch packet offered |
| fp_ready | output | 1 | Splitter idle, able to take a fetch packet |
| fp_data | input | 256 | Fetch packet, word k at bits [32k+31:32k] |
| ep_valid | output | 1 | Execute packet offered |
| ep_ready | input | 1 | Downstream takes the execute packet |
| ep_slots | output | 256 | Eight instruction lanes, lane j at bits [32j+31:32j] |
| ep_mask | output | 8 | Lanes holding an instruction |
| ep_compact | output | 8 | Lanes holding a zero-extended 16-bit instruction |
| ep_last | output | 1 | Final execute packet of the current fetch packet |

## Verification
The cycle timing the checks rely on is as follows.

- **First execute packet.** A fetch packet taken on a rising edge produces its first execute packet one register later, so it is visible in the following cycle.
- **Following execute packets.** Each later execute packet appears in the cycle after the handshake that retired the previous one.
- **Return of `fp_ready`.** `fp_ready` comes back one cycle after the handshake of the packet marked last.

The bench drives and samples on the falling edge only. It compares each execute packet in the half cycle before the edge that takes it, using the `ep_ready` value it has just set. It checks `fp_ready` at the falling edge just after each of these two events. During stalls it compares the outputs against the values seen one cycle earlier.

// File: rtl/fps_pkg.sv
package fps_pkg;

  // Width and value of the tag that marks a header word.
  localparam int unsigned MARK_W = 4;
  localparam logic [MARK_W-1:0] HDR_MARK = 4'b1110;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } fps_state_e;

endpackage

// File: rtl/fps_unpack.sv
// Turns one fetch packet into a flat, address-ordered instruction list.
module fps_unpack #(
  parameter int WORD_W   = 32,
  parameter int FP_WORDS = 8,
  parameter int MAX_INS  = 14,
  parameter int CNT_W    = 4
) (
  input  logic [FP_WORDS*WORD_W-1:0]     fp_data,
  output logic [MAX_INS-1:0][WORD_W-1:0] ins_o,
  output logic [MAX_INS-1:0]             cmp_o,
  output logic [MAX_INS-1:0]             par_o,
  output logic [CNT_W-1:0]               cnt_o
);
  import fps_pkg::*;

  localparam int HALF_W  = WORD_W / 2;
  localparam int FLG_W   = FP_WORDS - 1;
  localparam int PAR_LSB = WORD_W - MARK_W - MAX_INS;

  logic [WORD_W-1:0] hdr;
  logic              is_hdr;

  assign hdr    = fp_data[FP_WORDS*WORD_W-1 -: WORD_W];
  assign is_hdr = (hdr[WORD_W-1 -: MARK_W] == HDR_MARK);

  always_comb begin
    logic [CNT_W-1:0]  n;
    logic [WORD_W-1:0] w;
    ins_o = '0;
    cmp_o = '0;
    par_o = '0;
    n     = '0;
    w     = '0;
    if (!is_hdr) begin
      // Plain packet: every word is one instruction.
      for (int k = 0; k < FP_WORDS; k++) begin
        w        = fp_data[k*WORD_W +: WORD_W];
        ins_o[n] = w;
        par_o[n] = w[0];
        n        = n + 1'b1;
      end
    end else begin
      // Header packet: the top word is dropped, flagged words split in two.
      for (int k = 0; k < FLG_W; k++) begin
        w = fp_data[k*WORD_W +: WORD_W];
        if (hdr[k]) begin
          for (int h = 0; h < 2; h++) begin
            ins_o[n] = {{HALF_W{1'b0}}, w[h*HALF_W +: HALF_W]};
            cmp_o[n] = 1'b1;
            par_o[n] = hdr[PAR_LSB + 2*k + h];
            n        = n + 1'b1;
          end
        end else begin
          ins_o[n] = w;
          par_o[n] = w[0];
          n        = n + 1'b1;
        end
      end
    end
    cnt_o = n;
  end

endmodule

// File: rtl/fps_group.sv
// From the current read pointer, gathers the chained run of instructions
// that forms the next execute packet.
module fps_group #(
  parameter int WORD_W  = 32,
  parameter int MAX_INS = 14,
  parameter int ISSUE_W = 8,
  parameter int CNT_W   = 4
) (
  input  logic [MAX_INS-1:0][WORD_W-1:0] ins_i,
  input  logic [MAX_INS-1:0]             cmp_i,
  input  logic [MAX_INS-1:0]             par_i,
  input  logic [CNT_W-1:0]               cnt_i,
  input  logic [CNT_W-1:0]               ptr_i,
  output logic [ISSUE_W-1:0][WORD_W-1:0] slot_o,
  output logic [ISSUE_W-1:0]             mask_o,
  output logic [ISSUE_W-1:0]             cmp_o,
  output logic [CNT_W-1:0]               len_o,
  output logic                           last_o
);
  localparam int IW = CNT_W + 1;

  always_comb begin
    logic          go;
    logic [IW-1:0] idx;
    logic [IW-1:0] endp;
    slot_o = '0;
    mask_o = '0;
    cmp_o  = '0;
    len_o  = '0;
    go     = 1'b1;
    idx    = '0;
    for (int j = 0; j < ISSUE_W; j++) begin
      idx = {1'b0, ptr_i} + IW'(j);
      if (go && (idx < {1'b0, cnt_i})) begin
        slot_o[j] = ins_i[idx[CNT_W-1:0]];
        cmp_o[j]  = cmp_i[idx[CNT_W-1:0]];
        mask_o[j] = 1'b1;
        len_o     = len_o + 1'b1;
        // A chain stops at a clear bit or at the packet's final instruction.
        if (!par_i[idx[CNT_W-1:0]] || (idx == {1'b0, cnt_i} - 1'b1)) begin
          go = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
    endp   = {1'b0, ptr_i} + {1'b0, len_o};
    last_o = (endp >= {1'b0, cnt_i});
  end

endmodule

// File: rtl/fetch_packet_splitter.sv
module fetch_packet_splitter #(
  parameter int WORD_W   = 32,
  parameter int FP_WORDS = 8,
  parameter int ISSUE_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fp_valid,
  output logic                        fp_ready,
  input  logic [FP_WORDS*WORD_W-1:0]  fp_data,
  output logic                        ep_valid,
  input  logic                        ep_ready,
  output logic [ISSUE_W*WORD_W-1:0]   ep_slots,
  output logic [ISSUE_W-1:0]          ep_mask,
  output logic [ISSUE_W-1:0]          ep_compact,
  output logic                        ep_last
);
  import fps_pkg::*;

  localparam int MAX_INS = 2 * (FP_WORDS - 1);
  localparam int CNT_W   = $clog2(MAX_INS + 1);

  fps_state_e state_q;

  logic [MAX_INS-1:0][WORD_W-1:0] ins_d, ins_q;
  logic [MAX_INS-1:0]             cmp_d, cmp_q;
  logic [MAX_INS-1:0]             par_d, par_q;
  logic [CNT_W-1:0]               cnt_d, cnt_q;
  logic [CNT_W-1:0]               ptr_q;

  logic [ISSUE_W-1:0][WORD_W-1:0] slot_w;
  logic [CNT_W-1:0]               len_w;
  logic                           last_w;
  logic                           take_fp;
  logic                           take_ep;

  fps_unpack #(
    .WORD_W  (WORD_W),
    .FP_WORDS(FP_WORDS),
    .MAX_INS (MAX_INS),
    .CNT_W   (CNT_W)
  ) u_unpack (
    .fp_data(fp_data),
    .ins_o  (ins_d),
    .cmp_o  (cmp_d),
    .par_o  (par_d),
    .cnt_o  (cnt_d)
  );

  fps_group #(
    .WORD_W (WORD_W),
    .MAX_INS(MAX_INS),
    .ISSUE_W(ISSUE_W),
    .CNT_W  (CNT_W)
  ) u_group (
    .ins_i (ins_q),
    .cmp_i (cmp_q),
    .par_i (par_q),
    .cnt_i (cnt_q),
    .ptr_i (ptr_q),
    .slot_o(slot_w),
    .mask_o(ep_mask),
    .cmp_o (ep_compact),
    .len_o (len_w),
    .last_o(last_w)
  );

  assign fp_ready = (state_q == ST_IDLE);
  assign ep_valid = (state_q == ST_ISSUE);
  assign ep_slots = slot_w;
  assign ep_last  = last_w;
  assign take_fp  = fp_valid && fp_ready;
  assign take_ep  = ep_valid && ep_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ins_q   <= '0;
      cmp_q   <= '0;
      par_q   <= '0;
      cnt_q   <= '0;
      ptr_q   <= '0;
    end else if (take_fp) begin
      state_q <= ST_ISSUE;
      ins_q   <= ins_d;
      cmp_q   <= cmp_d;
      par_q   <= par_d;
      cnt_q   <= cnt_d;
      ptr_q   <= '0;
    end else if (take_ep) begin
      if (last_w) begin
        state_q <= ST_IDLE;
        ptr_q   <= '0;
      end else begin
        ptr_q <= ptr_q + len_w;
      end
    end
  end

endmodule

// File: rtl/fps_checks.sv
module fps_checks #(
  parameter int WORD_W  = 32,
  parameter int ISSUE_W = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      fp_valid,
  input logic                      fp_ready,
  input logic                      ep_valid,
  input logic                      ep_ready,
  input logic [ISSUE_W*WORD_W-1:0] ep_slots,
  input logic [ISSUE_W-1:0]        ep_mask,
  input logic [ISSUE_W-1:0]        ep_compact,
  input logic                      ep_last
);
  localparam int HALF_W = WORD_W / 2;

  p_one_side_r11: assert property (@(posedge clk) disable iff (rst)
    fp_ready != ep_valid);

  p_accept_r11: assert property (@(posedge clk) disable iff (rst)
    fp_valid && fp_ready |=> ep_valid);

  p_last_idle_r11: assert property (@(posedge clk) disable iff (rst)
    ep_valid && ep_ready && ep_last |=> fp_ready);

  p_more_r9: assert property (@(posedge clk) disable iff (rst)
    ep_valid && ep_ready && !ep_last |=> ep_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ep_valid && !ep_ready |=> ep_valid && $stable(ep_slots) && $stable(ep_mask)
      && $stable(ep_compact) && $stable(ep_last));

  p_contig_r3: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> ep_mask[0] && ((ep_mask & (ep_mask + 1'b1)) == '0));

  p_cmp_in_mask_r6: assert property (@(posedge clk) disable iff (rst)
    ep_valid |-> ((ep_compact & ~ep_mask) == '0));

  for (genvar j = 0; j < ISSUE_W; j++) begin : g_lane
    p_zext_r6: assert property (@(posedge clk) disable iff (rst)
      ep_valid && ep_compact[j] |-> ep_slots[j*WORD_W + HALF_W +: HALF_W] == '0);
    p_empty_lane_r3: assert property (@(posedge clk) disable iff (rst)
      ep_valid && !ep_mask[j] |-> ep_slots[j*WORD_W +: WORD_W] == '0);
  end

endmodule

bind fetch_packet_splitter fps_checks #(
  .WORD_W (WORD_W),
  .ISSUE_W(ISSUE_W)
) i_fps_checks (
  .clk       (clk),
  .rst       (rst),
  .fp_valid  (fp_valid),
  .fp_ready  (fp_ready),
  .ep_valid  (ep_valid),
  .ep_ready  (ep_ready),
  .ep_slots  (ep_slots),
  .ep_mask   (ep_mask),
  .ep_compact(ep_compact),
  .ep_last   (ep_last)
);

// File: tb/test_fetch_packet_splitter.sv
module test_fetch_packet_splitter;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fp_valid = 1'b0;
  logic         fp_ready;
  logic [255:0] fp_data = '0;
  logic         ep_valid;
  logic         ep_ready = 1'b0;
  logic [255:0] ep_slots;
  logic [7:0]   ep_mask;
  logic [7:0]   ep_compact;
  logic         ep_last;

  always #4 clk = ~clk;

  fetch_packet_splitter i_fetch_packet_splitter (
    .clk       (clk),
    .rst       (rst),
    .fp_valid  (fp_valid),
    .fp_ready  (fp_ready),
    .fp_data   (fp_data),
    .ep_valid  (ep_valid),
    .ep_ready  (ep_ready),
    .ep_slots  (ep_slots),
    .ep_mask   (ep_mask),
    .ep_compact(ep_compact),
    .ep_last   (ep_last)
  );

  typedef struct {
    logic [255:0] slots;
    logic [7:0]   mask;
    logic [7:0]   cmp;
    logic         last;
    string        req;
  } exp_t;

  exp_t q[$];

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 0;
  bit  rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected execute packets, derived from the requirement text.
  task automatic model(input logic [255:0] d, input string req);
    logic [31:0] ins [14];
    bit          c [14];
    bit          p [14];
    int          n = 0;
    int          s = 0;
    logic [31:0] wd;
    if (d[255:252] != 4'b1110) begin          // R5: plain packet
      for (int w = 0; w < 8; w++) begin
        wd = d[w*32 +: 32];
        ins[n] = wd; c[n] = 0; p[n] = wd[0]; n++;   // R2
      end
    end else begin
      for (int w = 0; w < 7; w++) begin
        wd = d[w*32 +: 32];
        if (d[224 + w]) begin                       // R6
          for (int h = 0; h < 2; h++) begin
            ins[n] = {16'h0, wd[h*16 +: 16]};
            c[n] = 1;
            p[n] = d[224 + 14 + 2*w + h];           // R7
            n++;
          end
        end else begin
          ins[n] = wd; c[n] = 0; p[n] = wd[0]; n++;
        end
      end
    end
    while (s < n) begin
      exp_t e;
      int   k = 0;
      e.slots = '0; e.mask = '0; e.cmp = '0; e.req = req;
      forever begin
        e.slots[k*32 +: 32] = ins[s+k];
        e.mask[k] = 1'b1;
        e.cmp[k]  = c[s+k];
        k++;
        if (s + k == n || k == 8 || !p[s+k-1]) break;   // R4, R8
      end
      e.last = (s + k == n);
      s += k;
      q.push_back(e);
    end
  endtask

  task automatic send(input logic [255:0] d, input string req);
    model(d, req);
    @(negedge clk);
    while (!fp_ready) @(negedge clk);
    fp_valid = 1'b1;
    fp_data  = d;
    @(negedge clk);
    fp_valid = 1'b0;
    check(fp_ready == 1'b0, "R11", "fp_ready after accept", 256'(fp_ready), 256'(0));
    check(ep_valid == 1'b1, "R11", "ep_valid after accept", 256'(ep_valid), 256'(1));
  endtask

  function automatic logic [255:0] plain(input logic [31:0] base, input logic [7:0] par);
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[i*32 +: 32] = (base + 32'(i * 16'h0110)) & 32'hFFFF_FFFE | 32'(par[i]);
    return d;
  endfunction

  // Monitor and scoreboard, all on the falling edge.
  bit           idle_due = 0;
  bit           stall_prev = 0;
  logic [255:0] h_slots;
  logic [7:0]   h_mask, h_cmp;
  logic         h_last;

  always @(negedge clk) begin
    if (idle_due) begin
      check(fp_ready == 1'b1, "R11", "fp_ready after last EP", 256'(fp_ready), 256'(1));
      idle_due = 0;
    end
    if (stall_prev) begin
      check(ep_valid && ep_slots == h_slots && ep_mask == h_mask && ep_compact == h_cmp
            && ep_last == h_last, "R10", "outputs during stall", ep_slots, h_slots);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ep_ready = rst ? 1'b0 : (rdy_rand ? (lfsr[0] | lfsr[5]) : 1'b1);
    if (!rst && ep_valid && ep_ready) begin
      if (q.size() == 0) begin
        check(0, "R9", "unexpected execute packet", ep_slots, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(ep_mask == e.mask, e.req, "ep_mask", 256'(ep_mask), 256'(e.mask));
        check(ep_slots == e.slots, e.req, "ep_slots", ep_slots, e.slots);
        check(ep_compact == e.cmp, e.req, "ep_compact", 256'(ep_compact), 256'(e.cmp));
        check(ep_last == e.last, "R9", "ep_last", 256'(ep_last), 256'(e.last));
        if (e.last) idle_due = 1;
      end
    end
    stall_prev = !rst && ep_valid && !ep_ready;
    h_slots = ep_slots; h_mask = ep_mask; h_cmp = ep_compact; h_last = ep_last;
  end

  initial begin
    logic [255:0] d;
    repeat (3) @(negedge clk);
    check(ep_valid == 1'b0, "R1", "ep_valid in reset", 256'(ep_valid), 256'(0));
    check(fp_ready == 1'b1, "R1", "fp_ready in reset", 256'(fp_ready), 256'(1));
    check(ep_mask == 8'h0, "R1", "ep_mask in reset", 256'(ep_mask), 256'(0));
    rst = 1'b0;

    // R2: all chain bits clear, eight single packets
    send(plain(32'h0100_0000, 8'h00), "R2");
    // R3/R4: all chain bits set including the last word
    send(plain(32'h0200_0000, 8'hFF), "R4");
    // R4: following packet starts fresh
    send(plain(32'h0300_0000, 8'h01), "R4");
    // R2: mixed grouping {0,1} {2,3,4} {5} {6,7}
    send(plain(32'h0400_0000, 8'b0100_1101), "R2");
    rdy_rand = 1;
    // R5: near-marker tops stay plain
    d = plain(32'h0500_0000, 8'b1010_0110); d[255:252] = 4'b0110;
    send(d, "R5");
    d = plain(32'h0600_0000, 8'b0011_1000); d[255:252] = 4'b1111;
    send(d, "R5");
    // R8: fourteen chained compact halves -> 8 then 6
    d = plain(32'h1357_9BDE, 8'h00);
    d[255:224] = {4'b1110, 14'h3FFF, 7'h0, 7'h7F};
    send(d, "R8");
    // R6: mixed compact and 32-bit words
    d = plain(32'h2468_ACE0, 8'b0101_0011);
    d[255:224] = {4'b1110, 14'b10_0110_0101_1001, 7'h0, 7'b0100101};
    send(d, "R6");
    // R7: no flagged words, header chain bits ignored, word bit 0 rules
    d = plain(32'h3000_0000, 8'h00);
    d[255:224] = {4'b1110, 14'h3FFF, 7'h0, 7'h00};
    send(d, "R7");
    // R7: halves chained by header only
    d = plain(32'h4000_0000, 8'hFF);
    d[255:224] = {4'b1110, 14'b01_0101_0101_0101, 7'h0, 7'b0001111};
    send(d, "R7");
    // R3/R10: random packets under random back-pressure
    for (int i = 0; i < 24; i++) begin
      for (int w = 0; w < 8; w++) d[w*32 +: 32] = $urandom;
      if (i % 2 == 1) d[255:252] = 4'b1110;
      send(d, "R3");
    end
    rdy_rand = 0;
    for (int i = 0; i < 6; i++) begin
      for (int w = 0; w < 8; w++) d[w*32 +: 32] = $urandom;
      if (i % 3 != 0) d[255:252] = 4'b1110;
      send(d, "R6");
    end
    while (q.size() != 0 || !fp_ready) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule